// File: doc/BRIEF.md
# Expansion Slot Slave Decoder

This block sits on the slave side of an expansion card attached to a 32-bit host bus with dynamic bus sizing. When the host places an address on the bus and asserts its address strobe, the block looks at the top address byte and a single low address bit. From these it decides whether the access targets the card's byte-wide identity ROM, the card's register device, or nothing on the card. It decodes no other address bits, so both targets alias across the card window.

A ROM access gets an active-low ROM select and a cycle acknowledge that tells the host it is talking to an 8-bit port. The acknowledge lines are released to high impedance whenever the ROM is not selected. A register access gets an active-low chip select. The register device returns its own 32-bit acknowledge, but its slave strobe is built here from the host data strobe rather than the address strobe. A read/write line that glitches while the address strobe asserts is therefore never captured.

Selects are registered. Each one appears on the clock edge after the address strobe is seen asserted and is dropped on the edge after the host releases it.

Top module: `exp_slot_slave_dec`

## Requirements
- R1: After synchronous reset, rom_sel_n=1, reg_cs_n=1, rom_ack_oe=0, rom_ack0_n=1, rom_ack1_n=1 and reg_strb_n=1.
- R2: A clock edge that samples as_n=0, addr_top=0xF9 and addr_b8=1 drives rom_sel_n to 0 from that edge on.
- R3: While rom_sel_n=0, rom_ack_oe=1, rom_ack0_n=0 and rom_ack1_n=1 (the 8-bit port code). Otherwise rom_ack_oe=0 and both acknowledge lines rest at 1.
- R4: A clock edge that samples as_n=0, addr_top=0xF9 and addr_b8=0 drives reg_cs_n to 0 from that edge on.
- R5: A clock edge that samples as_n=1 returns rom_sel_n, reg_cs_n and the ROM acknowledge to idle.
- R6: A clock edge that samples as_n=0 with addr_top other than 0xF9 leaves every select idle and the ROM acknowledge undriven.
- R7: rom_sel_n and reg_cs_n are never 0 at the same time, including when the address moves between ROM and register space while as_n stays 0.
- R8: reg_strb_n is 0 exactly when reg_cs_n=0 and ds_n=0. It follows ds_n in the same cycle with no clock delay.
- R9: No select or acknowledge is asserted before the first clock edge that samples as_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Host address strobe, active low |
| ds_n | input | 1 | Host data strobe, active low |
| addr_top | input | 8 | Host address bits 31..24 |
| addr_b8 | input | 1 | Host address bit 8 (1 = ROM, 0 = registers) |
| rom_sel_n | output | 1 | ROM select, active low |
| rom_ack_oe | output | 1 | Output enable of the ROM acknowledge drivers |
| rom_ack0_n | output | 1 | ROM acknowledge bit 0, active low |
| rom_ack1_n | output | 1 | ROM acknowledge bit 1, active low |
| reg_cs_n | output | 1 | Register device chip select, active low |
| reg_strb_n | output | 1 | Register device slave strobe, active low |

## Verification
Two functions can fall in the same cycle: the ROM select dropping and the register chip select rising. This happens when the host moves addr_b8 from 1 to 0 while holding the address strobe low. The bench provokes this hand-over on purpose in both directions. It then checks at the next sample that exactly one select is low and that the acknowledge follows the ROM select. A checker property forbids both selects being low together at every edge, and another ties the data-strobe-derived register strobe to the chip select in the same cycle.

// File: rtl/slvdec_pkg.sv
package slvdec_pkg;

    typedef struct packed {
        logic rom;
        logic regs;
    } sel_t;

    typedef struct packed {
        logic oe;
        logic ack0_n;
        logic ack1_n;
    } ack_t;

    localparam sel_t SEL_NONE = '{rom: 1'b0, regs: 1'b0};
    localparam ack_t ACK_BYTE = '{oe: 1'b1, ack0_n: 1'b0, ack1_n: 1'b1};
    localparam ack_t ACK_IDLE = '{oe: 1'b0, ack0_n: 1'b1, ack1_n: 1'b1};

    function automatic sel_t pick_target(input logic strobe_on, input logic window_hit,
                                         input logic low_bit);
        sel_t s;
        s.rom  = strobe_on & window_hit & low_bit;
        s.regs = strobe_on & window_hit & ~low_bit;
        return s;
    endfunction

endpackage

// File: rtl/slvdec_addr_decode.sv
module slvdec_addr_decode
    import slvdec_pkg::*;
#(
    parameter int           TOP_W = 8,
    parameter logic [TOP_W-1:0] BASE = 8'hF9
) (
    input  logic             as_n,
    input  logic [TOP_W-1:0] addr_top,
    input  logic             addr_b8,
    output sel_t             sel_next
);
    logic hit;

    assign hit      = (addr_top == BASE);
    assign sel_next = pick_target(~as_n, hit, addr_b8);
endmodule

// File: rtl/slvdec_sel_stage.sv
module slvdec_sel_stage
    import slvdec_pkg::*;
#(
    parameter int NSEL = 2
) (
    input  logic clk,
    input  logic rst,
    input  sel_t sel_next,
    output sel_t sel_q
);
    logic [NSEL-1:0] d_vec;
    logic [NSEL-1:0] q_vec;

    assign d_vec = {sel_next.rom, sel_next.regs};

    for (genvar i = 0; i < NSEL; i++) begin : g_flop
        always_ff @(posedge clk) begin
            if (rst) q_vec[i] <= 1'b0;
            else     q_vec[i] <= d_vec[i];
        end
    end

    assign sel_q.rom  = q_vec[NSEL-1];
    assign sel_q.regs = q_vec[0];
endmodule

// File: rtl/slvdec_ack_drive.sv
module slvdec_ack_drive
    import slvdec_pkg::*;
(
    input  sel_t sel_q,
    input  logic ds_n,
    output ack_t rom_ack,
    output logic strb_n
);
    always_comb begin
        rom_ack = sel_q.rom ? ACK_BYTE : ACK_IDLE;
        strb_n  = ~(sel_q.regs & ~ds_n);
    end
endmodule

// File: rtl/exp_slot_slave_dec.sv
module exp_slot_slave_dec
    import slvdec_pkg::*;
#(
    parameter int               TOP_W = 8,
    parameter logic [TOP_W-1:0] BASE  = 8'hF9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic             ds_n,
    input  logic [TOP_W-1:0] addr_top,
    input  logic             addr_b8,
    output logic             rom_sel_n,
    output logic             rom_ack_oe,
    output logic             rom_ack0_n,
    output logic             rom_ack1_n,
    output logic             reg_cs_n,
    output logic             reg_strb_n
);
    localparam int NSEL = $bits(sel_t);

    sel_t sel_next;
    sel_t sel_q;
    ack_t ack;

    slvdec_addr_decode #(.TOP_W(TOP_W), .BASE(BASE)) u_dec (
        .as_n     (as_n),
        .addr_top (addr_top),
        .addr_b8  (addr_b8),
        .sel_next (sel_next)
    );

    slvdec_sel_stage #(.NSEL(NSEL)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .sel_next (sel_next),
        .sel_q    (sel_q)
    );

    slvdec_ack_drive u_ack (
        .sel_q   (sel_q),
        .ds_n    (ds_n),
        .rom_ack (ack),
        .strb_n  (reg_strb_n)
    );

    assign rom_sel_n  = ~sel_q.rom;
    assign reg_cs_n   = ~sel_q.regs;
    assign rom_ack_oe = ack.oe;
    assign rom_ack0_n = ack.ack0_n;
    assign rom_ack1_n = ack.ack1_n;
endmodule

// File: rtl/exp_slot_slave_dec_chk.sv
module exp_slot_slave_dec_chk #(
    parameter int               TOP_W = 8,
    parameter logic [TOP_W-1:0] BASE  = 8'hF9
) (
    input logic             clk,
    input logic             rst,
    input logic             as_n,
    input logic             ds_n,
    input logic [TOP_W-1:0] addr_top,
    input logic             addr_b8,
    input logic             rom_sel_n,
    input logic             rom_ack_oe,
    input logic             rom_ack0_n,
    input logic             rom_ack1_n,
    input logic             reg_cs_n,
    input logic             reg_strb_n
);
    p_rom_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (!as_n && addr_top == BASE && addr_b8) |=> !rom_sel_n);

    p_byte_ack_r3: assert property (@(posedge clk) disable iff (rst)
        !rom_sel_n |-> (rom_ack_oe && !rom_ack0_n && rom_ack1_n));

    p_ack_idle_r3: assert property (@(posedge clk) disable iff (rst)
        rom_sel_n |-> (!rom_ack_oe && rom_ack0_n && rom_ack1_n));

    p_reg_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (!as_n && addr_top == BASE && !addr_b8) |=> !reg_cs_n);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (rom_sel_n && reg_cs_n && !rom_ack_oe));

    p_outside_r6: assert property (@(posedge clk) disable iff (rst)
        (addr_top != BASE) |=> (rom_sel_n && reg_cs_n && !rom_ack_oe));

    p_mutex_r7: assert property (@(posedge clk) disable iff (rst)
        (rom_sel_n || reg_cs_n));

    p_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (ds_n || reg_cs_n) |-> reg_strb_n);

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_sel_n) |-> $past(!as_n));
endmodule

bind exp_slot_slave_dec exp_slot_slave_dec_chk #(.TOP_W(TOP_W), .BASE(BASE)) u_chk (.*);

// File: tb/exp_slot_slave_dec_test.sv
module exp_slot_slave_dec_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       as_n = 1'b1;
    logic       ds_n = 1'b1;
    logic [7:0] addr_top = 8'h00;
    logic       addr_b8 = 1'b0;
    logic rom_sel_n, rom_ack_oe, rom_ack0_n, rom_ack1_n, reg_cs_n, reg_strb_n;

    int n_chk = 0;
    int n_bad = 0;
    logic m_rom = 1'b0;
    logic m_reg = 1'b0;

    always #4 clk = ~clk;

    exp_slot_slave_dec uut (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .addr_top(addr_top),
        .addr_b8(addr_b8), .rom_sel_n(rom_sel_n), .rom_ack_oe(rom_ack_oe),
        .rom_ack0_n(rom_ack0_n), .rom_ack1_n(rom_ack1_n), .reg_cs_n(reg_cs_n),
        .reg_strb_n(reg_strb_n)
    );

    task automatic cmp(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic exp_strb(input logic r, input logic d);
        return ~(r & ~d);
    endfunction

    task automatic chk_all(input string req);
        cmp(req, "rom_sel_n",  rom_sel_n,  ~m_rom);
        cmp(req, "reg_cs_n",   reg_cs_n,   ~m_reg);
        cmp(req, "rom_ack_oe", rom_ack_oe, m_rom);
        cmp(req, "rom_ack0_n", rom_ack0_n, ~m_rom);
        cmp(req, "rom_ack1_n", rom_ack1_n, 1'b1);
        cmp(req, "reg_strb_n", reg_strb_n, exp_strb(m_reg, ds_n));
        cmp(req, "select exclusivity", ~rom_sel_n & ~reg_cs_n, 1'b0);
    endtask

    // One bus cycle: drive at negedge, check combinational view before the edge
    // (R8 strobe, R9 no early select), then check registered result after it.
    task automatic step(input string req, input logic a, input logic d,
                        input logic [7:0] top, input logic b8);
        @(negedge clk);
        as_n = a; ds_n = d; addr_top = top; addr_b8 = b8;
        #1;
        chk_all("R9/R8 pre-edge");
        @(posedge clk);
        m_rom = ~a & (top == 8'hF9) & b8;
        m_reg = ~a & (top == 8'hF9) & ~b8;
        #1;
        chk_all(req);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1");
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3: ROM byte read, then R5 release
        step("R2", 1'b0, 1'b1, 8'hF9, 1'b1);
        step("R3", 1'b0, 1'b0, 8'hF9, 1'b1);
        step("R5", 1'b1, 1'b1, 8'hF9, 1'b1);
        // R4 / R8: register access with data strobe
        step("R4", 1'b0, 1'b1, 8'hF9, 1'b0);
        step("R8", 1'b0, 1'b0, 8'hF9, 1'b0);
        step("R8", 1'b0, 1'b1, 8'hF9, 1'b0);
        // R7: hand-over ROM <-> register with strobe held low
        step("R7", 1'b0, 1'b0, 8'hF9, 1'b1);
        step("R7", 1'b0, 1'b0, 8'hF9, 1'b0);
        step("R7", 1'b0, 1'b0, 8'hF9, 1'b1);
        step("R5", 1'b1, 1'b0, 8'hF9, 1'b1);
        // R6: outside the card window, near misses on the top byte
        step("R6", 1'b0, 1'b0, 8'hF8, 1'b1);
        step("R6", 1'b0, 1'b0, 8'hFB, 1'b0);
        step("R6", 1'b0, 1'b0, 8'h79, 1'b1);
        // R9: strobe dropped mid-cycle, no select without address strobe
        step("R9", 1'b1, 1'b0, 8'hF9, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic       a  = ($urandom_range(0, 3) == 0);
            logic       d  = $urandom_range(0, 1);
            logic [7:0] t  = ($urandom_range(0, 9) < 7) ? 8'hF9 : 8'($urandom);
            logic       b8 = $urandom_range(0, 1);
            step("R2/R4/R7 random", a, d, t, b8);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule